// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block decodes the write-command protocol of a parallel NOR flash and owns a small on-chip storage array. A bus master writes command bytes, the low byte of the data bus, and the block walks short multi-cycle sequences: arm-then-store programming, immediate block erase with a confirm cycle, a lock/unlock pair and a query entry. Each accepted sequence updates a status byte that carries a ready flag and two sticky error flags.

A read returns one of four sources, chosen by the command latched at the time of the read. These are array contents, the status byte, identifier codes or bytes of a capability table. The bus is built from `LANES` byte-wide devices side by side. Status, identifier and table bytes are copied into every byte lane. A write-protect input turns program and erase into error-reporting no-ops. Programming and erasure complete at once, with no modelled busy time.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode with no sequence pending and a status byte of 0x80.
- R2: A first-cycle command of 0xFF, 0xF0 or 0x00 selects array reads. Any first-cycle byte that is not a defined command also selects array reads and leaves status unchanged.
- R3: Command 0x10 or 0x40 arms a program. The next write stores its full data word at its word address and sets status bit 7. The sequence then returns to idle, and reads return status until the next command.
- R4: Command 0x20 erases at once the block containing the written word address (blocks of 2^BLK_W words), filling it with all-ones. A second write of 0xD0 completes the sequence and keeps status reads. A second write of 0xFF, or any other value, returns to array reads.
- R5: Status bit 7 means ready, bit 4 means program error and bit 5 means erase error. The error bits stay set until command 0x50, which clears the whole status byte to 0x00 and selects array reads.
- R6: While wp_i is high, a program sets status bit 4 and an erase sets status bit 5. In both cases the array is left unchanged.
- R7: Command 0x70 selects status reads and 0x90 selects identifier reads. Neither opens a second cycle, so the next write is decoded as a new command.
- R8: In identifier mode, word offset 0 returns MFR_CODE and offset 1 returns DEV_CODE in every lane. Other offsets return zero. Only the low 8 address bits are decoded.
- R9: After 0x98, reads return the table byte at the word address in every lane. The table holds 0x51, 0x52, 0x59 at 0x10-0x12 and 0x01 at 0x13. It holds 0x31 at 0x15 and ADDR_W at 0x27. It holds 0x01 at 0x2C and the block count minus one at 0x2D/0x2E. It holds the block size in words divided by 256 at 0x2F/0x30. All other addresses return zero.
- R10: In query mode a further write of 0xFF returns to array reads, and any other value keeps query mode.
- R11: Command 0x60 followed by 0xD0 or 0x01 completes with status bit 7 set and status reads selected. Any other second value selects array reads. Neither outcome alters the array.
- R12: rvalid_o rises exactly one cycle after rd_en_i. The data comes from the source selected before any write in the same cycle, and status reads carry the status byte in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 8*LANES | Write data; bits 7:0 carry the command byte |
| wp_i | input | 1 | Write protect |
| rdata_o | output | 8*LANES | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |

## Verification
The hardest states to reach are those where the sticky error bits coexist with later successful operations. Reaching them needs write protect raised across a program and an erase, then lowered again before a status read, a clear and a fresh operation that sets only the ready flag. The stimulus chains these sequences in order, without intermediate resets. It also covers a read strobe in the same cycle as a mode-changing write and an erase whose confirm byte is rejected after the block has already been wiped. A behavioural reference model follows every write and checks every returned read word.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2,
    SRC_QUERY  = 2'd3
  } rd_src_e;

  localparam logic [7:0] OP_READ0   = 8'h00;
  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_UNLOCK  = 8'h01;
  localparam logic [7:0] OP_READ1   = 8'hF0;
  localparam logic [7:0] OP_READ2   = 8'hFF;

  localparam int ST_READY = 7;
  localparam int ST_EERR  = 5;
  localparam int ST_PERR  = 4;
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] op_i,
  input  logic       wp_i,
  output rd_src_e    src_o,
  output logic [7:0] status_o,
  output logic       prog_o,
  output logic       erase_o
);
  logic       second_q, second_d;
  logic [7:0] cmd_q, cmd_d;
  logic [7:0] st_q, st_d;
  logic       clr;

  always_comb begin
    second_d = second_q;
    cmd_d    = cmd_q;
    st_d     = st_q;
    prog_o   = 1'b0;
    erase_o  = 1'b0;
    clr      = 1'b0;
    if (wr_en_i) begin
      if (!second_q) begin
        unique case (op_i)
          OP_READ0, OP_READ1, OP_READ2: cmd_d = OP_READ0;
          OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
            cmd_d    = op_i;
            second_d = 1'b1;
          end
          OP_ERASE: begin
            cmd_d    = op_i;
            second_d = 1'b1;
            if (wp_i) st_d[ST_EERR] = 1'b1;
            else      erase_o = 1'b1;
            st_d[ST_READY] = 1'b1;
          end
          OP_CLEAR: begin
            clr   = 1'b1;
            st_d  = 8'h00;
            cmd_d = OP_READ0;
          end
          OP_STATUS, OP_IDENT: cmd_d = op_i;
          default: cmd_d = OP_READ0;
        endcase
      end else begin
        unique case (cmd_q)
          OP_PROG_A, OP_PROG_B: begin
            if (wp_i) st_d[ST_PERR] = 1'b1;
            else      prog_o = 1'b1;
            st_d[ST_READY] = 1'b1;
            second_d = 1'b0;
          end
          OP_ERASE: begin
            second_d = 1'b0;
            if (op_i == OP_CONFIRM) st_d[ST_READY] = 1'b1;
            else                    cmd_d = OP_READ0;
          end
          OP_LOCK: begin
            second_d = 1'b0;
            if (op_i == OP_CONFIRM || op_i == OP_UNLOCK) st_d[ST_READY] = 1'b1;
            else                                         cmd_d = OP_READ0;
          end
          OP_QUERY: begin
            if (op_i == OP_READ2) begin
              second_d = 1'b0;
              cmd_d    = OP_READ0;
            end
          end
          default: begin
            second_d = 1'b0;
            cmd_d    = OP_READ0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      cmd_q    <= OP_READ0;
      st_q     <= 8'h80;
    end else begin
      second_q <= second_d;
      cmd_q    <= cmd_d;
      st_q     <= st_d;
    end
  end

  always_comb begin
    unique case (cmd_q)
      OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_STATUS: src_o = SRC_STATUS;
      OP_IDENT: src_o = SRC_ID;
      OP_QUERY: src_o = SRC_QUERY;
      default:  src_o = SRC_ARRAY;
    endcase
  end

  assign status_o = st_q;

  // R5: error flags survive everything except the clear command
  p_perr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q[ST_PERR]) && !$past(clr)) |-> st_q[ST_PERR]);
  p_eerr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q[ST_EERR]) && !$past(clr)) |-> st_q[ST_EERR]);
  // R3: a completed program leaves ready set and no sequence open
  p_prog_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> (st_q[ST_READY] && !second_q));
  // R7: status and identifier commands never open a second cycle
  p_single_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !second_q && (op_i == OP_STATUS || op_i == OP_IDENT)) |=> !second_q);
endmodule

// File: rtl/nor_cmd_array.sv
module nor_cmd_array #(
  parameter int ADDR_W = 10,
  parameter int BLK_W  = 8,
  parameter int LANES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [LANES-1:0]         wbe_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [8*LANES-1:0]       wdata_i,
  input  logic                     erase_i,
  input  logic [ADDR_W-BLK_W-1:0]  eblk_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [8*LANES-1:0]       rdata_o
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int DATA_W = 8 * LANES;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < WORDS; w++) begin
      if (erase_i && ((ADDR_W'(w) >> BLK_W) == ADDR_W'(eblk_i))) begin
        mem[w] <= '1;
      end else if (we_i && (waddr_i == ADDR_W'(w))) begin
        for (int l = 0; l < LANES; l++) begin
          if (wbe_i[l]) mem[w][8*l +: 8] <= wdata_i[8*l +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

  // R4: the decoder never programs and erases in the same cycle
  p_single_op_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && erase_i));
endmodule

// File: rtl/nor_cmd_info.sv
module nor_cmd_info
  import nor_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         BLK_W    = 8,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'h18
) (
  input  rd_src_e           src_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o
);
  localparam int          BLOCKS   = 1 << (ADDR_W - BLK_W);
  localparam int          BLK_WRDS = 1 << BLK_W;
  localparam logic [15:0] BLK_M1   = 16'(BLOCKS - 1);
  localparam logic [31:0] BLK_SZ   = 32'(BLK_WRDS);

  logic [7:0] lo;
  logic       hi_zero;
  logic [7:0] id_b, q_b;

  assign lo      = addr_i[7:0];
  assign hi_zero = (addr_i >> 8) == '0;

  always_comb begin
    unique case (lo)
      8'h00:   id_b = MFR_CODE;
      8'h01:   id_b = DEV_CODE;
      default: id_b = 8'h00;
    endcase
  end

  always_comb begin
    q_b = 8'h00;
    if (hi_zero) begin
      unique case (lo)
        8'h10: q_b = 8'h51;
        8'h11: q_b = 8'h52;
        8'h12: q_b = 8'h59;
        8'h13: q_b = 8'h01;
        8'h15: q_b = 8'h31;
        8'h27: q_b = 8'(ADDR_W);
        8'h2C: q_b = 8'h01;
        8'h2D: q_b = BLK_M1[7:0];
        8'h2E: q_b = BLK_M1[15:8];
        8'h2F: q_b = BLK_SZ[15:8];
        8'h30: q_b = BLK_SZ[23:16];
        default: q_b = 8'h00;
      endcase
    end
  end

  assign byte_o = (src_i == SRC_ID) ? id_b : q_b;
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         BLK_W    = 8,
  parameter int         LANES    = 2,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'h18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [8*LANES-1:0]   wdata_i,
  input  logic                 wp_i,
  output logic [8*LANES-1:0]   rdata_o,
  output logic                 rvalid_o
);
  localparam int DATA_W = 8 * LANES;

  rd_src_e           src;
  logic [7:0]        status, info_b;
  logic              prog, erase;
  logic [DATA_W-1:0] arr_rd, side_d, side_q;
  logic              arr_sel_q, rvalid_q;

  nor_cmd_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .op_i     (wdata_i[7:0]),
    .wp_i     (wp_i),
    .src_o    (src),
    .status_o (status),
    .prog_o   (prog),
    .erase_o  (erase)
  );

  nor_cmd_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .LANES(LANES)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (prog),
    .wbe_i   ({LANES{1'b1}}),
    .waddr_i (addr_i),
    .wdata_i (wdata_i),
    .erase_i (erase),
    .eblk_i  (addr_i[ADDR_W-1:BLK_W]),
    .re_i    (rd_en_i),
    .raddr_i (addr_i),
    .rdata_o (arr_rd)
  );

  nor_cmd_info #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .MFR_CODE(MFR_CODE),
                 .DEV_CODE(DEV_CODE)) u_info (
    .src_i  (src),
    .addr_i (addr_i),
    .byte_o (info_b)
  );

  assign side_d = (src == SRC_STATUS) ? {LANES{status}} : {LANES{info_b}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      arr_sel_q <= 1'b1;
      side_q    <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) begin
        arr_sel_q <= (src == SRC_ARRAY);
        side_q    <= side_d;
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = arr_sel_q ? arr_rd : side_q;

  // R12: fixed one-cycle read latency
  p_read_lat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_no_spurious_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  // R6: protection keeps the array untouched
  p_wp_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !(prog || erase));
endmodule

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int BLK_W  = 8;
  localparam int LANES  = 2;
  localparam int DW     = 8 * LANES;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int LIMIT  = 50000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0, re = 1'b0, wp = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .rd_en_i(re), .addr_i(addr),
    .wdata_i(wd), .wp_i(wp), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // reference model: 0 array, 1 status, 2 id, 3 query
  logic [DW-1:0] mm [WORDS];
  int       m_cmd = 0;
  bit       m_sec = 0;
  logic [7:0] m_st = 8'h80;
  bit       e_valid = 0;
  logic [DW-1:0] e_data = '0;

  function automatic int src_of(int c);
    if (c == 'h10 || c == 'h40 || c == 'h20 || c == 'h60 || c == 'h70) return 1;
    if (c == 'h90) return 2;
    if (c == 'h98) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] qbyte(int a);
    if (a > 255) return 8'h00;
    case (a)
      'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
      'h13: return 8'h01; 'h15: return 8'h31; 'h27: return 8'd10;
      'h2C: return 8'h01; 'h2D: return 8'd3;  'h2F: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] rep(logic [7:0] b);
    return {LANES{b}};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_sec = 0; m_st = 8'h80; e_valid = 0;
    end else begin
      int b;
      int s;
      e_valid = re;
      if (re) begin
        s = src_of(m_cmd);
        if (s == 0) e_data = mm[addr];
        else if (s == 1) e_data = rep(m_st);
        else if (s == 2) e_data = rep((addr[7:0] == 0) ? 8'h89 : (addr[7:0] == 1) ? 8'h18 : 8'h00);
        else e_data = rep(qbyte(int'(addr)));
      end
      if (we) begin
        b = int'(wd[7:0]);
        if (!m_sec) begin
          if (b == 'h00 || b == 'hF0 || b == 'hFF) m_cmd = 0;
          else if (b == 'h10 || b == 'h40 || b == 'h60 || b == 'h98) begin m_cmd = b; m_sec = 1; end
          else if (b == 'h20) begin
            m_cmd = b; m_sec = 1; m_st[7] = 1;
            if (wp) m_st[5] = 1;
            else for (int i = 0; i < WORDS; i++) if ((i >> BLK_W) == (int'(addr) >> BLK_W)) mm[i] = '1;
          end
          else if (b == 'h50) begin m_st = 0; m_cmd = 0; end
          else if (b == 'h70 || b == 'h90) m_cmd = b;
          else m_cmd = 0;
        end else begin
          if (m_cmd == 'h10 || m_cmd == 'h40) begin
            if (wp) m_st[4] = 1; else mm[addr] = wd;
            m_st[7] = 1; m_sec = 0;
          end else if (m_cmd == 'h20) begin
            m_sec = 0;
            if (b == 'hD0) m_st[7] = 1; else m_cmd = 0;
          end else if (m_cmd == 'h60) begin
            m_sec = 0;
            if (b == 'hD0 || b == 'h01) m_st[7] = 1; else m_cmd = 0;
          end else if (m_cmd == 'h98) begin
            if (b == 'hFF) begin m_sec = 0; m_cmd = 0; end
          end else begin m_sec = 0; m_cmd = 0; end
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rvalid !== e_valid) begin
        errors++;
        $display("FAIL %s rvalid: got %0b expected %0b", cur_req, rvalid, e_valid);
      end else if (e_valid && rdata !== e_data) begin
        errors++;
        $display("FAIL %s rdata: got %h expected %h", cur_req, rdata, e_data);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT) begin
      errors++;
      $display("FAIL R12 watchdog: got %0d cycles expected below %0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic wr(input int a, input int d);
    addr = ADDR_W'(a); wd = DW'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    cur_req = req;
    addr = ADDR_W'(a); re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    checks++;
    if (rdata !== DW'(exp)) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, rdata, DW'(exp));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rvalid in reset: got %0b expected 0", rvalid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: status after reset
    wr(0, 'h70);
    rd_chk(0, 'h8080, "R1");
    // R4: wipe every block with confirm
    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin wr(k << BLK_W, 'h20); wr(k << BLK_W, 'hD0); end
    rd_chk(0, 'h8080, "R4");
    wr(0, 'hFF);
    rd_chk(7, 'hFFFF, "R4");
    // R3: program through both opcodes
    cur_req = "R3";
    wr(0, 'h40); wr(5, 'h1234);
    rd_chk(5, 'h8080, "R3");
    wr(0, 'hFF);
    rd_chk(5, 'h1234, "R3");
    wr(0, 'h10); wr('h3FF, 'hABCD);
    wr(0, 'hF0);
    rd_chk('h3FF, 'hABCD, "R2");
    // R2: unknown command and 0x00 both give array reads
    wr(0, 'h70); wr(0, 'h33);
    rd_chk(5, 'h1234, "R2");
    wr(0, 'h70); wr(0, 'h00);
    rd_chk(5, 'h1234, "R2");
    // R4: erase happens before a rejected confirm
    wr(0, 'h40); wr('h123, 'h7777);
    wr('h1F0, 'h20); wr('h1F0, 'h55);
    rd_chk('h123, 'hFFFF, "R4");
    rd_chk(5, 'h1234, "R4");
    wr('h300, 'h20); wr('h300, 'hFF);
    rd_chk('h3FF, 'hFFFF, "R4");
    // R6: write protect
    wp = 1'b1;
    wr(0, 'h40); wr(5, 'h5555);
    rd_chk(0, 'h9090, "R6");
    wr(0, 'h20); wr(0, 'hD0);
    rd_chk(0, 'hB0B0, "R6");
    wp = 1'b0;
    wr(0, 'hFF);
    rd_chk(5, 'h1234, "R6");
    // R5: sticky until clear, clear zeroes ready too
    wr(0, 'h70);
    rd_chk(0, 'hB0B0, "R5");
    wr(0, 'h50);
    rd_chk(5, 'h1234, "R5");
    wr(0, 'h70);
    rd_chk(0, 'h0000, "R5");
    // R11: lock pair
    wr(0, 'h60); wr(0, 'hD0);
    rd_chk(0, 'h8080, "R11");
    wr(0, 'h60); wr(0, 'h01);
    rd_chk(0, 'h8080, "R11");
    wr(0, 'h60); wr(5, 'h77);
    rd_chk(5, 'h1234, "R11");
    // R8: identifier reads
    wr(0, 'h90);
    rd_chk(0, 'h8989, "R8");
    rd_chk(1, 'h1818, "R8");
    rd_chk(2, 'h0000, "R8");
    rd_chk('h101, 'h1818, "R8");
    // R7: next write after 0x90 is a fresh command
    wr(0, 'h70);
    rd_chk(0, 'h8080, "R7");
    // R9: query table
    wr(0, 'h98);
    rd_chk('h10, 'h5151, "R9");
    rd_chk('h12, 'h5959, "R9");
    rd_chk('h27, 'h0A0A, "R9");
    rd_chk('h2D, 'h0303, "R9");
    rd_chk('h2F, 'h0101, "R9");
    rd_chk('h20, 'h0000, "R9");
    rd_chk('h110, 'h0000, "R9");
    // R10: stays in query until 0xFF
    wr(0, 'h42);
    rd_chk('h11, 'h5252, "R10");
    wr(0, 'hFF);
    rd_chk(5, 'h1234, "R10");
    // R12: read and mode-changing write in the same cycle
    wr(0, 'h70);
    cur_req = "R12";
    addr = '0; wd = DW'('hFF); we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    checks++;
    if (rdata !== DW'('h8080)) begin
      errors++;
      $display("FAIL R12 same-cycle read: got %h expected %h", rdata, DW'('h8080));
    end
    rd_chk(5, 'h1234, "R12");
    rd_chk('h3FF, 'hFFFF, "R12");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule